// File: doc/BRIEF.md
# Indirect-Y Address Sequencer

This block generates the bus address for an 8-bit CPU's "zero-page pointer plus Y" addressing mode. It works one cycle at a time. When it is started, it latches the operand byte (a zero-page location that holds a 16-bit pointer), the Y index and an access mode. It then drives a fixed series of bus cycles. Each cycle carries its address, a read or write strobe and a cycle index. In the last cycle it presents the 16-bit effective address together with a one-cycle done pulse. The ALU, the opcode decode and the write data are handled elsewhere. The sequencer only decides where each access goes and when.

The sequence runs as follows:
1. Read the low pointer byte from page zero.
2. Read the high pointer byte from the next page-zero location. This fetch wraps inside page zero.
3. Access the address formed from the high byte and the low byte plus Y, with the carry not yet applied.
4. If the low-byte sum carried, increment the high byte, then make the final access.

For read-modify-write and store modes the access in step 3 is always a dummy read, so these modes always take four cycles. Plain reads take three cycles when there is no carry and four when there is.

Top module: `iy_addr_seq`

## Requirements
- R1: While rst_ni is low, and in idle after reset, busy_o, done_o, bus_rd_o, bus_wr_o and pc_inc_o are 0, cyc_idx_o is 0 and bus_addr_o is 0x0000.
- R2: A start_i sampled high in idle causes, in the next cycle, a read at address {0x00, operand} with cyc_idx_o = 0 and pc_inc_o = 1. pc_inc_o is 0 in every other cycle.
- R3: The second cycle reads address {0x00, (operand + 1) mod 256} with cyc_idx_o = 1, so the pointer fetch never leaves page zero.
- R4: In mode RMW (mode_i = 2'b01) or STORE (2'b10), the third cycle is always a read at {high byte, (low byte + Y) mod 256}, with cyc_idx_o = 2 and done_o = 0, whether or not the sum carried.
- R5: In mode RMW, the fourth cycle is a read at {(high byte + carry) mod 256, (low byte + Y) mod 256}, with cyc_idx_o = 3, done_o = 1 and ea_o equal to that address. Mode 2'b11 behaves exactly as RMW.
- R6: In mode STORE, the fourth cycle is a write (bus_wr_o = 1, bus_rd_o = 0) at the corrected address, with cyc_idx_o = 3, done_o = 1 and ea_o equal to that address.
- R7: In mode READ (2'b00) without a carry, the third cycle is the final read, with done_o = 1 and ea_o equal to its address. With a carry, that cycle is a dummy read and a fourth read goes to the corrected address, as in R5.
- R8: start_i is ignored whenever busy_o is 1. A started sequence is not altered, and no further access follows it until a new start_i is sampled in idle.
- R9: In every busy cycle exactly one of bus_rd_o and bus_wr_o is 1, and in idle neither is. done_o lasts one cycle and is followed by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence; sampled only in idle |
| mode_i | input | 2 | 00 read, 01 read-modify-write, 10 store, 11 as 01 |
| zp_op_i | input | 8 | Zero-page location of the pointer |
| y_i | input | 8 | Index added to the pointer |
| bus_rdata_i | input | 8 | Read data, valid in the strobed cycle |
| bus_addr_o | output | 16 | Address of the current access |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| cyc_idx_o | output | 2 | Position of the access in the sequence |
| pc_inc_o | output | 1 | Operand byte consumed; advance the program counter |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Final cycle of the sequence |
| ea_o | output | 16 | Effective address, valid while done_o is 1 |

## Verification
The assertions assume that bus_rdata_i is settled before the clock edge that ends each read cycle. They also assume that reset is released between edges. The bench models page zero as a combinational memory that answers from bus_addr_o, so read data always settles within the strobed cycle. It changes start_i, mode_i, zp_op_i and y_i only on falling edges. The operands are picked so that the corners are hit:
- a carry and no carry in every mode;
- a pointer at the last page-zero location, whose high byte wraps to location 0;
- a corrected address that wraps past 0xFFFF.

// File: rtl/iy_seq_pkg.sv
package iy_seq_pkg;
  localparam int unsigned IDX_W = 2;

  localparam logic [1:0] MODE_READ  = 2'b00;
  localparam logic [1:0] MODE_RMW   = 2'b01;
  localparam logic [1:0] MODE_STORE = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLO,
    ST_PHI,
    ST_FIX,
    ST_FIN
  } iy_state_e;
endpackage

// File: rtl/iy_seq_fsm.sv
module iy_seq_fsm
  import iy_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic       carry_i,
  output iy_state_e  state_o,
  output logic [1:0] mode_q_o,
  output logic       accept_o,
  output logic       busy_o,
  output logic       done_o
);
  iy_state_e  state_q, state_d;
  logic [1:0] mode_q;
  logic       short_read;

  assign accept_o   = (state_q == ST_IDLE) && start_i;
  assign short_read = (mode_q == MODE_READ) && !carry_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_PLO;
      ST_PLO:  state_d = ST_PHI;
      ST_PHI:  state_d = ST_FIX;
      ST_FIX:  state_d = short_read ? ST_IDLE : ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_READ;
    end else begin
      state_q <= state_d;
      if (accept_o) mode_q <= mode_i;
    end
  end

  assign state_o  = state_q;
  assign mode_q_o = mode_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN) || ((state_q == ST_FIX) && short_read);

  a_r9_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r8_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);
  a_r8_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(mode_q));
endmodule

// File: rtl/iy_seq_ptr.sv
module iy_seq_ptr
  import iy_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  iy_state_e         state_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] op_q_o,
  output logic [DATA_W-1:0] lo_q_o,
  output logic [DATA_W-1:0] hi_q_o,
  output logic              carry_q_o
);
  logic [DATA_W-1:0] op_q, y_q, lo_q, hi_q;
  logic              carry_q;
  logic [DATA_W:0]   lo_sum;

  assign lo_sum = {1'b0, rdata_i} + {1'b0, y_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      y_q     <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      carry_q <= 1'b0;
    end else begin
      if (accept_i) begin
        op_q    <= op_i;
        y_q     <= y_i;
        carry_q <= 1'b0;
      end
      if (state_i == ST_PLO) begin
        lo_q    <= lo_sum[DATA_W-1:0];
        carry_q <= lo_sum[DATA_W];
      end
      if (state_i == ST_PHI) hi_q <= rdata_i;
      // high byte is corrected only after the dummy access
      if ((state_i == ST_FIX) && carry_q) hi_q <= hi_q + 1'b1;
    end
  end

  assign op_q_o    = op_q;
  assign lo_q_o    = lo_q;
  assign hi_q_o    = hi_q;
  assign carry_q_o = carry_q;

  a_r5_hi_bump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_FIX) && carry_q) |=> (hi_q == $past(hi_q) + 1'b1));
  a_r4_lo_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_FIX) || (state_i == ST_FIN)) |-> $stable(lo_q));
  a_r8_op_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_PHI) || (state_i == ST_FIX) || (state_i == ST_FIN)) |-> $stable(op_q));
endmodule

// File: rtl/iy_seq_bus.sv
module iy_seq_bus
  import iy_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  iy_state_e         state_i,
  input  logic [1:0]        mode_q_i,
  input  logic [DATA_W-1:0] op_q_i,
  input  logic [DATA_W-1:0] lo_q_i,
  input  logic [DATA_W-1:0] hi_q_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              pc_inc_o
);
  localparam logic [DATA_W-1:0] ZP_PAGE = '0;

  always_comb begin
    addr_o   = '0;
    rd_o     = 1'b0;
    wr_o     = 1'b0;
    idx_o    = '0;
    pc_inc_o = 1'b0;
    unique case (state_i)
      ST_PLO: begin
        addr_o   = {ZP_PAGE, op_q_i};
        rd_o     = 1'b1;
        pc_inc_o = 1'b1;
      end
      ST_PHI: begin
        addr_o = {ZP_PAGE, op_q_i + 1'b1};
        rd_o   = 1'b1;
        idx_o  = IDX_W'(1);
      end
      ST_FIX: begin
        addr_o = {hi_q_i, lo_q_i};
        rd_o   = 1'b1;
        idx_o  = IDX_W'(2);
      end
      ST_FIN: begin
        addr_o = {hi_q_i, lo_q_i};
        wr_o   = (mode_q_i == MODE_STORE);
        rd_o   = (mode_q_i != MODE_STORE);
        idx_o  = IDX_W'(3);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iy_addr_seq.sv
module iy_addr_seq
  import iy_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] zp_op_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [IDX_W-1:0]  cyc_idx_o,
  output logic              pc_inc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] ea_o
);
  iy_state_e         state;
  logic [1:0]        mode_q;
  logic              accept, carry_q;
  logic [DATA_W-1:0] op_q, lo_q, hi_q;

  iy_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .carry_i  (carry_q),
    .state_o  (state),
    .mode_q_o (mode_q),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  iy_seq_ptr #(.DATA_W(DATA_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .state_i   (state),
    .op_i      (zp_op_i),
    .y_i       (y_i),
    .rdata_i   (bus_rdata_i),
    .op_q_o    (op_q),
    .lo_q_o    (lo_q),
    .hi_q_o    (hi_q),
    .carry_q_o (carry_q)
  );

  iy_seq_bus #(.DATA_W(DATA_W)) u_bus (
    .state_i  (state),
    .mode_q_i (mode_q),
    .op_q_i   (op_q),
    .lo_q_i   (lo_q),
    .hi_q_i   (hi_q),
    .addr_o   (bus_addr_o),
    .rd_o     (bus_rd_o),
    .wr_o     (bus_wr_o),
    .idx_o    (cyc_idx_o),
    .pc_inc_o (pc_inc_o)
  );

  assign ea_o = done_o ? {hi_q, lo_q} : '0;

  a_r9_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($countones({bus_rd_o, bus_wr_o}) == 1));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(bus_rd_o || bus_wr_o || pc_inc_o || done_o));
  a_r5_ea_on_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ea_o == bus_addr_o));
  a_r6_write_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o |-> (done_o && (cyc_idx_o == IDX_W'(3))));
  a_r2_pc_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |-> (bus_rd_o && (cyc_idx_o == '0)));
  a_r4_dummy_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc_idx_o == IDX_W'(2)) && !done_o && !$past(carry_q)) |=> $stable(bus_addr_o));
endmodule

// File: tb/iy_addr_seq_tb.sv
`timescale 1ns/1ps
module iy_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  mode;
  logic [7:0]  op, y;
  logic [7:0]  rdata;
  logic [15:0] bus_addr, ea;
  logic        bus_rd, bus_wr, pc_inc, busy, done;
  logic [1:0]  idx;

  always #4 clk = ~clk;

  iy_addr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .zp_op_i(op), .y_i(y), .bus_rdata_i(rdata),
    .bus_addr_o(bus_addr), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
    .cyc_idx_o(idx), .pc_inc_o(pc_inc), .busy_o(busy), .done_o(done), .ea_o(ea)
  );

  logic [7:0] zp_mem [256];
  assign rdata = (bus_addr[15:8] == 8'h00) ? zp_mem[bus_addr[7:0]] : 8'hA5;

  typedef struct {
    logic [15:0] addr;
    logic        wr;
    logic [1:0]  idx;
    logic        done;
    logic        pc;
    string       tag;
  } item_t;

  item_t exp_q[$];
  item_t mon_e;
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: one compare per strobed cycle
  always @(negedge clk) begin
    if (rst_n && (bus_rd || bus_wr)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected access", {16'h0, bus_addr}, 32'h0);
      end else begin
        mon_e = exp_q.pop_front();
        chk({bus_addr, bus_wr, bus_rd, idx, done, pc_inc} ==
            {mon_e.addr, mon_e.wr, !mon_e.wr, mon_e.idx, mon_e.done, mon_e.pc},
            mon_e.tag, "{addr,wr,rd,idx,done,pc}",
            {10'h0, bus_addr, bus_wr, bus_rd, idx, done, pc_inc},
            {10'h0, mon_e.addr, mon_e.wr, !mon_e.wr, mon_e.idx, mon_e.done, mon_e.pc});
        if (mon_e.done)
          chk(ea == mon_e.addr, mon_e.tag, "ea", {16'h0, ea}, {16'h0, mon_e.addr});
      end
    end
  end

  task automatic push(input logic [15:0] a, input logic w, input logic [1:0] i,
                      input logic d, input logic p, input string t);
    item_t it;
    it.addr = a; it.wr = w; it.idx = i; it.done = d; it.pc = p; it.tag = t;
    exp_q.push_back(it);
  endtask

  task automatic run(input logic [1:0] m, input logic [7:0] o, input logic [7:0] yy,
                     input bit poke);
    logic [7:0] lo, hi;
    logic [8:0] sum;
    logic       short_rd;
    string      ftag;
    lo  = zp_mem[o];
    hi  = zp_mem[o + 8'd1];
    sum = {1'b0, lo} + {1'b0, yy};
    short_rd = (m == 2'b00) && !sum[8];
    ftag = (m == 2'b10) ? "R6" : ((m == 2'b00) ? "R7" : "R5");
    push({8'h00, o}, 1'b0, 2'd0, 1'b0, 1'b1, "R2");
    push({8'h00, o + 8'd1}, 1'b0, 2'd1, 1'b0, 1'b0, "R3");
    push({hi, sum[7:0]}, 1'b0, 2'd2, short_rd, 1'b0, (m == 2'b00) ? "R7" : "R4");
    if (!short_rd)
      push({hi + {7'd0, sum[8]}, sum[7:0]}, m == 2'b10, 2'd3, 1'b1, 1'b0, ftag);
    @(negedge clk);
    start = 1'b1; mode = m; op = o; y = yy;
    @(negedge clk);
    start = poke;
    if (poke) begin
      op = o ^ 8'h5C; y = yy + 8'd77; mode = ~m;
    end
    do @(negedge clk); while (busy);
    start = 1'b0;
    chk(exp_q.size() == 0, ftag, "accesses outstanding", exp_q.size(), 32'd0);
    @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr && !done, poke ? "R8" : "R9", "idle after sequence",
        {busy, bus_rd, bus_wr, done}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) zp_mem[i] = 8'(i * 7 + 3);
    zp_mem[8'h10] = 8'h20; zp_mem[8'h11] = 8'h30;
    zp_mem[8'h20] = 8'hF0; zp_mem[8'h21] = 8'h12;
    zp_mem[8'h30] = 8'h80; zp_mem[8'h31] = 8'h44;
    zp_mem[8'h40] = 8'h01; zp_mem[8'h41] = 8'h66;
    zp_mem[8'hFF] = 8'hF0; zp_mem[8'h00] = 8'hFF;
    start = 1'b0; mode = 2'b00; op = 8'h00; y = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !bus_rd && !bus_wr && !done && !pc_inc && idx == 2'd0 && bus_addr == 16'h0,
        "R1", "reset outputs", {bus_addr, busy, bus_rd, bus_wr, done, pc_inc, idx}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr && !done && bus_addr == 16'h0,
        "R1", "idle after reset", {bus_addr, busy, bus_rd, bus_wr, done}, 32'h0);

    run(2'b01, 8'h10, 8'h05, 1'b0); // R5 no carry
    run(2'b01, 8'h20, 8'h20, 1'b0); // R4 R5 carry
    run(2'b10, 8'h30, 8'h90, 1'b0); // R6 carry
    run(2'b10, 8'h40, 8'h10, 1'b0); // R6 no carry, dummy still taken
    run(2'b00, 8'h10, 8'h05, 1'b0); // R7 short
    run(2'b00, 8'h20, 8'h20, 1'b0); // R7 long
    run(2'b01, 8'hFF, 8'h10, 1'b0); // R3 wrap, R5 16-bit wrap
    run(2'b11, 8'h30, 8'h90, 1'b0); // R5 alias mode
    run(2'b10, 8'h20, 8'h20, 1'b1); // R8 start held busy
    run(2'b00, 8'h40, 8'h10, 1'b1); // R8 short read with start held

    repeat (3) @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr, "R9", "final idle", {busy, bus_rd, bus_wr}, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule